// File: doc/BRIEF.md
# PCM highway time-slot port

This block moves one voice sample per frame between a parallel sample interface and a serial PCM highway. The highway carries a bit clock, a frame-sync strobe, a receive-data line into the port and a transmit-data line out of it. Many ports can share one highway: each one claims a slot that starts at a programmable bit offset after the frame strobe and spans 8 bits (companded code) or 16 bits (linear word). The port drives the transmit line only inside its own slot, and it asserts an active-low slot-enable output for the whole of that slot.

Timing comes either from the bus, in slave mode, or from the port itself, in master mode. In master mode it divides the system clock to make a bit clock and frames of 256 or 193 bits, halved for a 16 kHz frame rate. In both modes the port counts bit clocks between frame strobes and works out on its own whether the highway runs at the E-1 rate (256 bits per 8 kHz frame) or the T-1 rate (193 bits per 8 kHz frame). The edge that launches transmit data can be the rising edge or the falling edge of the bit clock. Receive data is always captured on the opposite edge. All highway lines are sampled in the system-clock domain, so the highway clock must be much slower than the system clock.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, slot_n is 1, hw_dx_en is 0, rx_valid is 0, rate_ok is 0 and rate_t1 is 0.
- R2: Bit 0 of a frame is the bit-clock rising edge at which hw_fs_i is first seen high after being low at the previous rising edge. The transmit slot covers bits slot_off to slot_off+L-1, where L is 16 when wide=1 and 8 when wide=0. During those bits hw_dx_en is 1 and slot_n is 0. During every other bit hw_dx_en is 0 and slot_n is 1.
- R3: With wide=0, tx_sample[7:0] is sent MSB first. The received 8-bit code lands in rx_sample[7:0], and rx_sample[15:8] reads 0.
- R4: With wide=1, all 16 bits of tx_sample are sent MSB first, and the 16 received bits fill rx_sample MSB first.
- R5: With tx_fall=0, each transmit bit changes on the rising edge that starts its bit period, and receive data is captured on the falling edge in the middle of that period. With tx_fall=1, each transmit bit changes on the falling edge of its bit period, and receive data is captured on the next rising edge.
- R6: rx_valid pulses for one system-clock cycle, once per frame, after the last slot bit is captured. rx_sample takes the new word in the same cycle. Receive-line values outside the slot do not affect rx_sample.
- R7: The transmit word is taken from tx_sample when the first slot bit is launched. A change of tx_sample later in the slot does not alter the bits sent in that frame.
- R8: With fast16k=0, rate detection counts bit clocks between the last two frame starts. A count of 193 gives rate_ok=1 and rate_t1=1. A count of 256 gives rate_ok=1 and rate_t1=0. Any other count gives rate_ok=0. The flags update at each frame start, from the second frame start onward.
- R9: With fast16k=1, a count of 128 gives rate_ok=1 and rate_t1=0, and a count of 96 or 97 gives rate_ok=1 and rate_t1=1.
- R10: With master=1, hw_clk_o stays high for HALF system-clock cycles and low for HALF cycles. A frame lasts 256 bit clocks (mst_t1=0) or 193 (mst_t1=1), halved with truncation when fast16k=1. hw_fs_o changes only when hw_clk_o falls, and it is high for one bit period ahead of each frame start. The port frames itself from this clock and strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| master | input | 1 | 1: port generates bit clock and frame strobe |
| mst_t1 | input | 1 | Master frame length: 1 = 193 bits, 0 = 256 bits |
| fast16k | input | 1 | 16 kHz frame rate |
| wide | input | 1 | 1: 16-bit linear word, 0: 8-bit code |
| tx_fall | input | 1 | 1: launch on falling edge, capture on rising edge |
| slot_off | input | POS_W | Slot start, in bits after frame start |
| tx_sample | input | 16 | Sample to transmit |
| rx_sample | output | 16 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe for a new rx_sample |
| hw_clk_i | input | 1 | Highway bit clock in (slave) |
| hw_fs_i | input | 1 | Highway frame strobe in (slave) |
| hw_dr | input | 1 | Highway receive data |
| hw_clk_o | output | 1 | Generated bit clock (master) |
| hw_fs_o | output | 1 | Generated frame strobe (master) |
| hw_dx | output | 1 | Highway transmit data |
| hw_dx_en | output | 1 | Drive enable for hw_dx (0 = released) |
| slot_n | output | 1 | Active-low slot enable |
| rate_t1 | output | 1 | Detected highway is at the T-1 rate |
| rate_ok | output | 1 | Detected bit count matches a known rate |

## Verification
The hardest case to reach is one where the transmit and receive slot edges of one frame fall on different kinds of bit-clock edge. This happens at the frame boundary: a slot at offset 0 launches on the very edge that opens the frame, and with falling-edge launch the last capture lands on a rising edge of the next bit. The bench drives the highway clock and strobe itself, bit by bit. It runs slots at offset 0 and at offsets near the end of the frame, in both edge pairings. A behavioural model of the bit index is checked on every bit, and noise is driven on the receive line outside the slot. The transmit word is overwritten in mid-slot, and frames of 193, 256, 200, 128 and 97 bits exercise the rate decision.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int HALF    = 2,
  parameter int POS_W   = 10,
  parameter int T1_BITS = 193,
  parameter int E1_BITS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             mst_t1,
  input  logic             fast16k,
  input  logic             wide,
  input  logic             tx_fall,
  input  logic [POS_W-1:0] slot_off,
  input  logic [15:0]      tx_sample,
  output logic [15:0]      rx_sample,
  output logic             rx_valid,
  input  logic             hw_clk_i,
  input  logic             hw_fs_i,
  input  logic             hw_dr,
  output logic             hw_clk_o,
  output logic             hw_fs_o,
  output logic             hw_dx,
  output logic             hw_dx_en,
  output logic             slot_n,
  output logic             rate_t1,
  output logic             rate_ok
);
  localparam int HW = $clog2(HALF + 1);
  localparam logic [POS_W-1:0] PMAX = '1;
  localparam logic [POS_W-1:0] T1L  = POS_W'(T1_BITS);
  localparam logic [POS_W-1:0] E1L  = POS_W'(E1_BITS);
  localparam logic [POS_W-1:0] THR  = POS_W'((T1_BITS + E1_BITS) / 2);

  logic [HW-1:0]    hcnt;
  logic             mclk, mfs;
  logic [POS_W-1:0] mbit, mlen;

  assign mlen = (mst_t1 ? T1L : E1L) >> fast16k;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt <= '0; mclk <= 1'b0; mfs <= 1'b0; mbit <= '0;
    end else if (!master) begin
      hcnt <= '0; mclk <= 1'b0; mfs <= 1'b0; mbit <= '0;
    end else if (hcnt == HW'(HALF - 1)) begin
      hcnt <= '0;
      mclk <= ~mclk;
      if (!mclk) mbit <= (mbit >= mlen - 1'b1) ? '0 : mbit + 1'b1;
      else       mfs  <= (mbit == mlen - 1'b1);
    end else
      hcnt <= hcnt + 1'b1;

  assign hw_clk_o = mclk;
  assign hw_fs_o  = mfs;

  logic             bclk, fs, bclk_q, fs_prev, framed, mvalid;
  logic             rise, fall, fstart, tx_ev, rx_ev, tx_in, rx_in, rx_last;
  logic [POS_W-1:0] pos, pos_nx, tx_idx, len, meas;
  logic [3:0]       tk, rk;
  logic [15:0]      txw, rxsh;

  assign bclk   = master ? mclk : hw_clk_i;
  assign fs     = master ? mfs  : hw_fs_i;
  assign rise   = bclk & ~bclk_q;
  assign fall   = ~bclk & bclk_q;
  assign fstart = rise & fs & ~fs_prev;
  assign pos_nx = fstart ? '0 : (pos == PMAX ? PMAX : pos + 1'b1);
  assign tx_ev  = tx_fall ? fall : rise;
  assign rx_ev  = tx_fall ? rise : fall;
  assign tx_idx = tx_fall ? pos : pos_nx;
  assign len    = wide ? POS_W'(16) : POS_W'(8);

  function automatic logic in_slot(input logic [POS_W-1:0] idx, off, n);
    return (idx >= off) && ({1'b0, idx} < ({1'b0, off} + {1'b0, n}));
  endfunction

  assign tx_in   = (framed | fstart) & in_slot(tx_idx, slot_off, len);
  assign rx_in   = framed & in_slot(pos, slot_off, len);
  assign tk      = 4'(tx_idx - slot_off);
  assign rk      = 4'(pos - slot_off);
  assign rx_last = rk == (wide ? 4'd15 : 4'd7);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_q <= 1'b0; fs_prev <= 1'b1; framed <= 1'b0; mvalid <= 1'b0;
      pos <= PMAX; meas <= '0; txw <= '0; rxsh <= '0;
      hw_dx <= 1'b0; hw_dx_en <= 1'b0; rx_sample <= '0; rx_valid <= 1'b0;
    end else begin
      bclk_q   <= bclk;
      rx_valid <= 1'b0;
      if (rise) begin
        fs_prev <= fs;
        pos     <= pos_nx;
        if (fstart) begin
          framed <= 1'b1;
          if (framed) begin
            meas   <= (pos == PMAX) ? PMAX : pos + 1'b1;
            mvalid <= 1'b1;
          end
        end
      end
      if (tx_ev) begin
        if (tx_in) begin
          hw_dx_en <= 1'b1;
          if (tk == 4'd0) begin
            txw   <= wide ? tx_sample : {tx_sample[7:0], 8'h00};
            hw_dx <= wide ? tx_sample[15] : tx_sample[7];
          end else
            hw_dx <= txw[4'd15 - tk];
        end else begin
          hw_dx_en <= 1'b0;
          hw_dx    <= 1'b0;
        end
      end
      if (rx_ev && rx_in) begin
        rxsh <= {rxsh[14:0], hw_dr};
        if (rx_last) begin
          rx_sample <= wide ? {rxsh[14:0], hw_dr} : {8'h00, rxsh[6:0], hw_dr};
          rx_valid  <= 1'b1;
        end
      end
    end

  assign slot_n = ~hw_dx_en;

  function automatic logic nominal(input logic [POS_W-1:0] m, input logic f16);
    if (f16) return m == (E1L >> 1) || m == (T1L >> 1) || m == (T1L >> 1) + 1'b1;
    return m == E1L || m == T1L;
  endfunction

  assign rate_ok = mvalid & nominal(meas, fast16k);
  assign rate_t1 = mvalid & (meas < (THR >> fast16k));

  // R2
  slot_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ev |=> $stable(slot_n));
  // R2
  drive_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_dx_en |-> framed);
  // R6
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_ev) && $past(rx_in));
  // R10
  fs_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master && $past(master) && $changed(hw_fs_o) |-> $fell(hw_clk_o));
endmodule

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;
  logic clk = 0, rst_n = 0;
  logic master = 0, mst_t1 = 0, fast16k = 0, wide = 0, tx_fall = 0;
  logic [9:0]  slot_off = 0;
  logic [15:0] tx_sample = 0, rx_sample;
  logic rx_valid, hw_clk_i = 0, hw_fs_i = 0, hw_dr = 0;
  logic hw_clk_o, hw_fs_o, hw_dx, hw_dx_en, slot_n, rate_t1, rate_ok;
  int checks = 0, errors = 0, cyc = 0, nvalid = 0;
  int mcnt = 0, mframe = 0, hrun = 0, mhigh = 0;
  logic ck_q = 0, fs_q = 0;

  always #4 clk = ~clk;

  pcm_slot_port uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_valid) nvalid <= nvalid + 1;
    ck_q <= hw_clk_o; fs_q <= hw_fs_o;
    if (hw_fs_o && !fs_q) begin mframe <= mcnt; mcnt <= 0; end
    else if (hw_clk_o && !ck_q) mcnt <= mcnt + 1;
    if (hw_clk_o) hrun <= hrun + 1;
    else if (ck_q) begin mhigh <= hrun; hrun <= 0; end
    if (cyc > 200000) begin
      errors = errors + 1;
      $display("FAIL watchdog act %0d exp below 200000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act %0h exp %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; hw_clk_i = 0; hw_fs_i = 0; hw_dr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // one bit period of the slave highway; model of slot and data in the bench
  task automatic hbit(int b, int nbits, logic [15:0] txw, logic [15:0] rxw,
                      bit chk, bit chg);
    int  L = wide ? 16 : 8;
    bit  ins = chk && b >= slot_off && b < slot_off + L;
    int  k = b - slot_off;
    logic eb = ins ? (wide ? txw[15-k] : txw[7-k]) : 1'b0;
    logic db = ins ? (wide ? rxw[15-k] : rxw[7-k]) : logic'(b[0] ^ b[2]);
    string dt = chg ? "R7" : (tx_fall ? "R5" : (wide ? "R4" : "R3"));
    hw_clk_i = 1;
    if (!tx_fall) hw_dr = db;
    repeat (4) @(negedge clk);
    if (chk && !tx_fall) begin
      check("R2", hw_dx_en, ins, "drive enable");
      check("R2", slot_n, !ins, "slot_n");
      if (ins) check(dt, hw_dx, eb, "tx bit");
    end
    hw_clk_i = 0; hw_fs_i = (b == nbits - 1);
    if (tx_fall) hw_dr = db;
    repeat (4) @(negedge clk);
    if (chk && tx_fall) begin
      check("R2", hw_dx_en, ins, "drive enable");
      check("R2", slot_n, !ins, "slot_n");
      if (ins) check(dt, hw_dx, eb, "tx bit");
    end
    if (chg && ins && k == 1) tx_sample = ~tx_sample;
  endtask

  task automatic frames(int nbits, int nfr, logic [15:0] txw, logic [15:0] rxw, bit chg);
    hbit(nbits - 1, nbits, txw, rxw, 0, 0);
    for (int f = 0; f < nfr; f++) begin
      int v0 = nvalid;
      tx_sample = txw;
      for (int b = 0; b < nbits; b++) hbit(b, nbits, txw, rxw, 1, chg);
      check("R6", nvalid - v0, 1, "rx strobes per frame");
      check(wide ? "R4" : "R3", rx_sample, wide ? rxw : {8'h00, rxw[7:0]}, "rx word");
    end
  endtask

  initial begin
    do_reset();
    check("R1", slot_n, 1, "slot_n"); check("R1", hw_dx_en, 0, "enable");
    check("R1", rx_valid, 0, "rx_valid"); check("R1", rate_ok, 0, "rate_ok");
    check("R1", rate_t1, 0, "rate_t1");

    wide = 0; tx_fall = 0; slot_off = 0; do_reset();
    frames(256, 2, 16'h00A5, 16'h003C, 0);
    check("R8", rate_ok, 1, "E-1 ok"); check("R8", rate_t1, 0, "E-1 class");

    wide = 1; tx_fall = 1; slot_off = 5; do_reset();
    frames(193, 2, 16'hC3A1, 16'h5E27, 0);
    check("R8", rate_ok, 1, "T-1 ok"); check("R8", rate_t1, 1, "T-1 class");

    wide = 1; tx_fall = 0; slot_off = 240; do_reset();
    frames(256, 2, 16'h8001, 16'hF00D, 1);
    check("R7", tx_sample, 16'h7FFE, "mid-slot rewrite applied");

    wide = 0; tx_fall = 1; slot_off = 180; do_reset();
    frames(200, 2, 16'h0096, 16'h00E1, 0);
    check("R8", rate_ok, 0, "off-rate count");

    wide = 0; tx_fall = 0; slot_off = 120; fast16k = 1; do_reset();
    frames(128, 2, 16'h005A, 16'h00FF, 0);
    check("R9", rate_ok, 1, "16k E-1 ok"); check("R9", rate_t1, 0, "16k E-1 class");
    slot_off = 3; do_reset();
    frames(97, 2, 16'h0001, 16'h0080, 0);
    check("R9", rate_ok, 1, "16k T-1 ok"); check("R9", rate_t1, 1, "16k T-1 class");

    fast16k = 0; master = 1; mst_t1 = 0; do_reset();
    repeat (3500) @(negedge clk);
    check("R10", mframe, 256, "master frame bits");
    check("R10", mhigh, 2, "master half period");
    check("R10", rate_ok, 1, "master self-framed");
    check("R10", rate_t1, 0, "master E-1 class");
    mst_t1 = 1; fast16k = 1; do_reset();
    repeat (1500) @(negedge clk);
    check("R10", mframe, 96, "master 16k T-1 bits");
    check("R10", rate_t1, 1, "master T-1 class");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule